// File: doc/BRIEF.md
# SEC-DED Check-Byte Encoder for 16-Bit Memory Words

This block turns a 16-bit data word into an 8-bit check byte for a single-error-correcting, double-error-detecting code. The check byte is written to memory next to the data word. On a later read, a decoder recomputes the byte and compares the two. Each check bit is a parity over a fixed subset of the data bits. Most check bits use even parity; one uses odd parity, so that an all-zero data word does not produce an all-zero check byte.

A width-mode input chooses how many check bits memory holds. In narrow mode only the six low check bits are kept, so the stored word is 22 bits. In wide mode all eight are kept, so the stored word is 24 bits. The encoder computes all eight bits in both modes. Next to the full check byte it provides a copy that is masked for storage, the keep mask, and the stored word width.

By default the outputs are purely combinational. A parameter adds one output register stage with a synchronous reset. The parity polarity of the two upper check bits is also set by parameters.

Top module: `secded_chk_encoder`

## Requirements
- R1: `chk_o` carries all eight check bits and has the same value in narrow mode and in wide mode for the same data word.
- R2: Check bit 0 is the even parity (XOR) of data bits 13, 12, 8, 7, 6, 5, 4 and 0.
- R3: Check bit 3 is the odd parity (XNOR) of data bits 14, 13, 10, 4, 3, 2, 1 and 0. With default polarities, data 0000h encodes to check byte 08h.
- R4: Flipping a single data bit j changes `chk_o` by that bit's column code. The codes are D15=F4h, D14=EAh, D13=69h, D12=25h, D11=F2h, D10=1Ah, D9=16h, D8=53h, D7=B1h, D6=A3h, D5=15h, D4=0Bh, D3=2Ch, D2=1Ch, D1=8Eh and D0=8Dh. Bits 5..0 of each code are that bit's single-error syndrome.
- R5: Check bits 1, 2, 4 and 5 are even parities. Check bit 6 covers data bits 15, 14, 13, 11 and 8. Check bit 7 covers data bits 15, 14, 11, 7, 6, 1 and 0. The polarity of bits 6 and 7 is set by `ODD_CB6` and `ODD_CB7`; 0 means even and is the default, and 1 inverts that bit.
- R6: Flipping data bits 11..8 together changes the check byte by ADh. Flipping data bits 13, 12, 10 and 9 together changes it by 40h.
- R7: When `narrow_i`=1, `keep_mask_o`=3Fh and `word_bits_o`=22. When `narrow_i`=0, `keep_mask_o`=FFh and `word_bits_o`=24.
- R8: `chk_store_o` equals `chk_o` ANDed with `keep_mask_o`, so bits 7..6 read 0 in narrow mode.
- R9: With `REG_OUT`=1, every output shows the value computed from the inputs at the previous rising clock edge. A synchronous `rst_i` drives every output to zero.
- R10: With `REG_OUT`=0, the outputs follow the inputs in the same cycle and `rst_i` has no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_i | input | 1 | Synchronous active-high reset of the output register |
| data_i | input | 16 | Data word to encode |
| narrow_i | input | 1 | 1 = keep 6 check bits (22-bit word), 0 = keep 8 (24-bit word) |
| chk_o | output | 8 | Full check byte |
| chk_store_o | output | 8 | Check byte masked to the bits that are stored |
| keep_mask_o | output | 8 | One bit per check bit that is stored |
| word_bits_o | output | 5 | Width of the stored word in bits |

## Verification
The bench applies every one-hot data word and compares the change from the zero-data byte with the column code of that bit. A mis-wired parity row shows up there as a wrong code for one specific data bit. A lost odd polarity on bit 3 makes zero data encode to 00h instead of 08h. The two four-bit group flips expose check bits 6 and 7 if they are built over subsets that break the ADh and 40h signatures. Random words are encoded in both modes to catch a width mode that wrongly alters the full byte, or a storage mask that lets bits 7..6 through in narrow mode. A second instance is registered and has bit 7 set to odd polarity; it exposes an off-by-one latency, a reset that leaves a stale byte, and a polarity parameter that is ignored.

// File: rtl/secded_enc_pkg.sv
package secded_enc_pkg;

    localparam int DATA_W      = 16;
    localparam int CHK_W       = 8;
    localparam int NARROW_CHK  = 6;
    localparam int WORD_BITS_W = 5;
    localparam int NARROW_BITS = DATA_W + NARROW_CHK;
    localparam int WIDE_BITS   = DATA_W + CHK_W;

    // Data-bit coverage of the two upper check bits
    localparam logic [DATA_W-1:0] ROW6_MASK = 16'hE900;
    localparam logic [DATA_W-1:0] ROW7_MASK = 16'hC8C3;

    // Index of the single lower check bit computed with odd parity
    localparam int ODD_LOW_ROW = 3;

    typedef struct packed {
        logic [CHK_W-1:0]       chk;
        logic [CHK_W-1:0]       store;
        logic [CHK_W-1:0]       keep;
        logic [WORD_BITS_W-1:0] bits;
    } enc_out_t;

    // Membership of one data bit in check bits 5..0 (its single-error syndrome)
    function automatic logic [NARROW_CHK-1:0] column_code(input int col);
        case (col)
            15:      return 6'h34;
            14:      return 6'h2A;
            13:      return 6'h29;
            12:      return 6'h25;
            11:      return 6'h32;
            10:      return 6'h1A;
            9:       return 6'h16;
            8:       return 6'h13;
            7:       return 6'h31;
            6:       return 6'h23;
            5:       return 6'h15;
            4:       return 6'h0B;
            3:       return 6'h2C;
            2:       return 6'h1C;
            1:       return 6'h0E;
            0:       return 6'h0D;
            default: return 6'h00;
        endcase
    endfunction

    // Data bits feeding one check bit: the lower rows are read from the column codes
    function automatic logic [DATA_W-1:0] row_mask(input int row);
        logic [DATA_W-1:0]     m;
        logic [NARROW_CHK-1:0] code;
        m = '0;
        if (row < NARROW_CHK) begin
            for (int j = 0; j < DATA_W; j++) begin
                code = column_code(j);
                m[j] = code[row];
            end
        end else if (row == NARROW_CHK) begin
            m = ROW6_MASK;
        end else begin
            m = ROW7_MASK;
        end
        return m;
    endfunction

    function automatic bit row_is_odd(input int row, input bit odd6, input bit odd7);
        if (row == ODD_LOW_ROW) return 1'b1;
        if (row == NARROW_CHK)  return odd6;
        if (row == NARROW_CHK + 1) return odd7;
        return 1'b0;
    endfunction

endpackage

// File: rtl/enc_parity_lane.sv
module enc_parity_lane
    import secded_enc_pkg::*;
#(
    parameter logic [DATA_W-1:0] MASK = '0,
    parameter bit                ODD  = 1'b0
) (
    input  logic [DATA_W-1:0] data_i,
    output logic              parity_o
);
    logic [DATA_W-1:0] picked;

    always_comb begin
        picked   = data_i & MASK;
        parity_o = (^picked) ^ ODD;
    end
endmodule

// File: rtl/enc_width_sel.sv
module enc_width_sel
    import secded_enc_pkg::*;
(
    input  logic                   narrow_i,
    output logic [CHK_W-1:0]       keep_o,
    output logic [WORD_BITS_W-1:0] bits_o
);
    for (genvar i = 0; i < CHK_W; i++) begin : g_keep
        if (i < NARROW_CHK) begin : g_always
            assign keep_o[i] = 1'b1;
        end else begin : g_wide_only
            assign keep_o[i] = ~narrow_i;
        end
    end

    assign bits_o = narrow_i ? WORD_BITS_W'(NARROW_BITS) : WORD_BITS_W'(WIDE_BITS);
endmodule

// File: rtl/secded_chk_encoder.sv
module secded_chk_encoder
    import secded_enc_pkg::*;
#(
    parameter bit REG_OUT = 1'b0,
    parameter bit ODD_CB6 = 1'b0,
    parameter bit ODD_CB7 = 1'b0
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic [DATA_W-1:0]      data_i,
    input  logic                   narrow_i,
    output logic [CHK_W-1:0]       chk_o,
    output logic [CHK_W-1:0]       chk_store_o,
    output logic [CHK_W-1:0]       keep_mask_o,
    output logic [WORD_BITS_W-1:0] word_bits_o
);
    logic [CHK_W-1:0]       chk_w;
    logic [CHK_W-1:0]       keep_w;
    logic [WORD_BITS_W-1:0] bits_w;
    enc_out_t               enc_d;
    enc_out_t               enc_q;
    enc_out_t               enc_o;

    for (genvar i = 0; i < CHK_W; i++) begin : g_lane
        enc_parity_lane #(
            .MASK (row_mask(i)),
            .ODD  (row_is_odd(i, ODD_CB6, ODD_CB7))
        ) u_lane (
            .data_i   (data_i),
            .parity_o (chk_w[i])
        );
    end

    enc_width_sel u_width (
        .narrow_i (narrow_i),
        .keep_o   (keep_w),
        .bits_o   (bits_w)
    );

    always_comb begin
        enc_d       = '0;
        enc_d.chk   = chk_w;
        enc_d.keep  = keep_w;
        enc_d.store = chk_w & keep_w;
        enc_d.bits  = bits_w;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            enc_q <= '0;
        end else begin
            enc_q <= enc_d;
        end
    end

    assign enc_o       = REG_OUT ? enc_q : enc_d;
    assign chk_o       = enc_o.chk;
    assign chk_store_o = enc_o.store;
    assign keep_mask_o = enc_o.keep;
    assign word_bits_o = enc_o.bits;
endmodule

// File: rtl/secded_chk_encoder_chk.sv
module secded_chk_encoder_chk #(
    parameter bit REG_OUT = 1'b0
) (
    input logic        clk_i,
    input logic        rst_i,
    input logic [15:0] data_i,
    input logic        narrow_i,
    input logic [7:0]  chk_o,
    input logic [7:0]  chk_store_o,
    input logic [7:0]  keep_mask_o,
    input logic [4:0]  word_bits_o
);
    // R8
    store_masked_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ((chk_store_o ^ chk_o) & keep_mask_o) == 8'h00);

    // R8
    store_upper_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (chk_store_o & ~keep_mask_o) == 8'h00);

    if (!REG_OUT) begin : g_comb
        // R2
        cb0_even_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            chk_o[0] == ($countones(data_i & 16'h31F1) % 2 == 1));
        // R3
        cb3_odd_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            chk_o[3] == ($countones(data_i & 16'h641F) % 2 == 0));
        // R7
        narrow_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            narrow_i |-> (keep_mask_o == 8'h3F && word_bits_o == 5'd22));
        // R7
        wide_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            !narrow_i |-> (keep_mask_o == 8'hFF && word_bits_o == 5'd24));
    end else begin : g_reg
        // R2
        cb0_even_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            1'b1 |=> chk_o[0] == ($countones($past(data_i) & 16'h31F1) % 2 == 1));
        // R3
        cb3_odd_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            1'b1 |=> chk_o[3] == ($countones($past(data_i) & 16'h641F) % 2 == 0));
        // R7
        narrow_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            narrow_i |=> (keep_mask_o == 8'h3F && word_bits_o == 5'd22));
        // R9
        reset_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            $fell(rst_i) |-> (chk_o == 8'h00 && keep_mask_o == 8'h00 && word_bits_o == 5'd0));
    end
endmodule

bind secded_chk_encoder secded_chk_encoder_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .data_i      (data_i),
    .narrow_i    (narrow_i),
    .chk_o       (chk_o),
    .chk_store_o (chk_store_o),
    .keep_mask_o (keep_mask_o),
    .word_bits_o (word_bits_o)
);

// File: tb/secded_chk_encoder_bench.sv
module secded_chk_encoder_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] data;
    logic        narrow;
    logic [7:0]  chk_c, store_c, keep_c, chk_r, store_r, keep_r;
    logic [4:0]  bits_c, bits_r;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    secded_chk_encoder u_secded_chk_encoder (
        .clk_i(clk), .rst_i(rst), .data_i(data), .narrow_i(narrow),
        .chk_o(chk_c), .chk_store_o(store_c), .keep_mask_o(keep_c), .word_bits_o(bits_c));

    secded_chk_encoder #(.REG_OUT(1'b1), .ODD_CB7(1'b1)) u_secded_chk_encoder_reg (
        .clk_i(clk), .rst_i(rst), .data_i(data), .narrow_i(narrow),
        .chk_o(chk_r), .chk_store_o(store_r), .keep_mask_o(keep_r), .word_bits_o(bits_r));

    localparam logic [15:0] ROWS [8] = '{16'h31F1, 16'h4F52, 16'h922F, 16'h641F,
                                         16'h8FA4, 16'hF8C8, 16'hE900, 16'hC8C3};
    localparam logic [7:0] COLS [16] = '{8'h8D, 8'h8E, 8'h1C, 8'h2C, 8'h0B, 8'h15, 8'hA3, 8'hB1,
                                         8'h53, 8'h16, 8'h1A, 8'hF2, 8'h25, 8'h69, 8'hEA, 8'hF4};

    function automatic logic [7:0] ref_chk(logic [15:0] d, bit odd7);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = ^(d & ROWS[i]);
        r[3] = ~r[3];
        r[7] = r[7] ^ odd7;
        return r;
    endfunction

    function automatic logic [7:0] ref_keep(bit nar);
        return nar ? 8'h3F : 8'hFF;
    endfunction

    task automatic expect_val(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, sample 1 ns after the next rising edge
    task automatic apply(logic [15:0] d, bit nar);
        @(negedge clk);
        data = d;
        narrow = nar;
        @(posedge clk);
        #1;
    endtask

    task automatic check_all(string tag);
        logic [7:0] e;
        e = ref_chk(data, 1'b0);
        expect_val({tag, " R2/R5 comb chk"}, chk_c, e);
        expect_val({tag, " R8 comb store"}, store_c, e & ref_keep(narrow));
        expect_val({tag, " R7 comb keep"}, keep_c, ref_keep(narrow));
        expect_val({tag, " R7 comb bits"}, {3'b0, bits_c}, narrow ? 8'd22 : 8'd24);
        e = ref_chk(data, 1'b1);
        expect_val({tag, " R9/R5 reg chk"}, chk_r, e);
        expect_val({tag, " R9 reg store"}, store_r, e & ref_keep(narrow));
        expect_val({tag, " R9 reg bits"}, {3'b0, bits_r}, narrow ? 8'd22 : 8'd24);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] base;
        logic [7:0] wide_chk;
        logic [15:0] x;
        void'($urandom(32'h5EC0DE));
        rst = 1'b1;
        data = 16'h1234;
        narrow = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R9: registered outputs cleared under reset
        expect_val("R9 reset chk", chk_r, 8'h00);
        expect_val("R9 reset keep", keep_r, 8'h00);
        expect_val("R9 reset bits", {3'b0, bits_r}, 8'h00);
        // R10: combinational outputs ignore reset
        expect_val("R10 comb during reset", chk_c, ref_chk(16'h1234, 1'b0));
        @(negedge clk);
        rst = 1'b0;

        // R3: zero data
        apply(16'h0000, 1'b0);
        expect_val("R3 zero wide", chk_c, 8'h08);
        check_all("zero-wide");
        apply(16'h0000, 1'b1);
        expect_val("R3 zero narrow", chk_c, 8'h08);
        expect_val("R8 zero narrow store", store_c, 8'h08);
        check_all("zero-narrow");
        apply(16'hFFFF, 1'b0);
        check_all("ones");

        // R4: one-hot words against the column codes
        for (int j = 0; j < 16; j++) begin
            apply(16'h0001 << j, j[0]);
            expect_val($sformatf("R4 column D%0d", j), chk_c ^ 8'h08, COLS[j]);
            check_all("onehot");
        end

        // R6: four-bit group flips
        x = 16'hA5C3;
        apply(x, 1'b0);
        base = chk_c;
        apply(x ^ 16'h0F00, 1'b0);
        expect_val("R6 group D11..D8", chk_c ^ base, 8'hAD);
        apply(x ^ 16'h3600, 1'b0);
        expect_val("R6 group D13,D12,D10,D9", chk_c ^ base, 8'h40);

        // R9/R10: latency of a single change
        apply(16'h0000, 1'b0);
        @(negedge clk);
        data = 16'h8000;
        #1;
        expect_val("R10 same-cycle comb", chk_c, 8'hFC);
        expect_val("R9 reg holds old value", chk_r, 8'h88);
        @(posedge clk);
        #1;
        expect_val("R9 reg after edge", chk_r, 8'h7C);

        // R1 and random coverage in both modes
        for (int k = 0; k < 300; k++) begin
            x = 16'($urandom);
            apply(x, 1'b0);
            wide_chk = chk_c;
            check_all("rand-wide");
            apply(x, 1'b1);
            expect_val("R1 mode-independent chk", chk_c, wide_chk);
            expect_val("R2 cb0", {7'b0, chk_c[0]}, {7'b0, ^(x & 16'h31F1)});
            check_all("rand-narrow");
        end

        // R9: reset mid-run clears the register
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        expect_val("R9 mid-run reset", chk_r, 8'h00);
        expect_val("R10 comb unaffected", chk_c, ref_chk(data, 1'b0));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule